// File: doc/BRIEF.md
# Prefix-Extended Operand Decoder

This block turns the narrow operand fields of a move-style instruction into full-width operands. An instruction can name a source register with a 4-bit field, or carry an 8-bit immediate in that field, and it names its destination with a 3-bit field. Registers in a peripheral module have 5-bit indices, and immediates are 16 bits wide. A prefix instruction loads an 8-bit prefix word that supplies the missing bits for the one instruction that comes right after it. The block widens the fields, reports whether a prefix was used (the access then costs two cycles), and flags any register index that does not exist in a 16-entry system module.

The prefix is tracked by a two-state machine. In `PFX_EMPTY` no prefix is held. The transition LOAD (a prefix instruction, no stall) moves it to `PFX_LIVE`. In `PFX_LIVE`, RELOAD (another prefix, no stall) stays in `PFX_LIVE` with the new word. EXPIRE (any non-stalled cycle without a prefix instruction) returns to `PFX_EMPTY` and zeroes the word. HOLD (stall asserted) keeps either state and its contents unchanged.

Top module: `pxd_operand_decoder`

## Requirements
- R1: The output source index is {prefix bit 0, source field bits [3:0]}. The output destination index is {prefix bits [2:1], destination field [2:0]}.
- R2: The output immediate is {prefix bits [7:0], source field [7:0]}.
- R3: A prefix loaded by a non-stalled prefix instruction applies only to the next non-stalled cycle, and it is cleared at the end of that cycle. If that cycle carries a new prefix instruction, the new word replaces the old one.
- R4: An instruction decoded with no live prefix gets zero in the upper immediate byte, source index bit 4 and destination index bits [4:3].
- R5: While stall is high, no instruction is accepted, out_valid is low one cycle later, and the prefix and its state are held.
- R6: out_err is high when a register source index of 10h or above targets a system module (in_src_sys=1), or when a destination index of 10h or above targets a system module (in_dst_sys=1). Immediate sources never raise it, and indices 8h–0Fh in a system module do not raise it.
- R7: The outputs are registered. A non-stalled, valid, non-prefix instruction sets out_valid and the operand outputs on the next clock edge. Prefix instructions never produce out_valid.
- R8: out_pfx_used is high on a decoded instruction that consumed a live prefix, which marks a two-cycle access.
- R9: A synchronous active-high reset clears the prefix, returns the state machine to `PFX_EMPTY` and drives every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freezes the decoder for this cycle |
| in_valid | input | 1 | An instruction is present |
| in_is_prefix | input | 1 | The instruction is a prefix load |
| in_pfx_byte | input | 8 | Prefix word carried by a prefix instruction |
| in_src_field | input | 8 | Source field: register index in [3:0], or 8-bit immediate |
| in_src_imm | input | 1 | The source field is an immediate |
| in_dst_field | input | 3 | Destination register field |
| in_src_sys | input | 1 | Source module is a 16-register system module |
| in_dst_sys | input | 1 | Destination module is a 16-register system module |
| out_valid | output | 1 | The decoded operands are valid |
| out_src_idx | output | 5 | Full source register index |
| out_dst_idx | output | 5 | Full destination register index |
| out_imm | output | 16 | Full immediate value |
| out_src_imm | output | 1 | The source is an immediate |
| out_pfx_used | output | 1 | A prefix was consumed (two-cycle access) |
| out_err | output | 1 | The register index does not exist in the addressed module |

## Verification
The bench checks the lifetime of the prefix. It places an idle cycle between a prefix and its instruction, and it places a second plain instruction after a prefixed one. A design that held the prefix too long would leak upper bits into the later instruction. Back-to-back prefixes and a stall between prefix and instruction expose a design that keeps the older word or drops a prefix during a stall. Error cases at indices 0Fh, 10h and 1Fh, in both system and peripheral modules and with an immediate source, catch an off-by-one range limit or a check applied to the wrong module. A reset issued while a prefix is live catches a prefix that survives reset.

// File: rtl/pxd_pkg.sv
package pxd_pkg;
    typedef enum logic [0:0] {
        PFX_EMPTY = 1'b0,
        PFX_LIVE  = 1'b1
    } pfx_state_e;
endpackage

// File: rtl/pxd_prefix_fsm.sv
module pxd_prefix_fsm
    import pxd_pkg::*;
#(
    parameter int PFX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall,
    input  logic             in_valid,
    input  logic             in_is_prefix,
    input  logic [PFX_W-1:0] in_pfx_byte,
    output logic             live,
    output logic [PFX_W-1:0] pfx_q
);
    pfx_state_e       state_q, state_d;
    logic [PFX_W-1:0] pfx_d;
    logic             pfx_cmd;

    assign pfx_cmd = in_valid && in_is_prefix && !stall;

    // State register with its prefix word
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PFX_EMPTY;
            pfx_q   <= '0;
        end else begin
            state_q <= state_d;
            pfx_q   <= pfx_d;
        end
    end

    // Transitions: LOAD, RELOAD, EXPIRE, HOLD
    always_comb begin
        state_d = state_q;
        pfx_d   = pfx_q;
        unique case (state_q)
            PFX_EMPTY: begin
                if (pfx_cmd) begin
                    state_d = PFX_LIVE;
                    pfx_d   = in_pfx_byte;
                end
            end
            PFX_LIVE: begin
                if (pfx_cmd) begin
                    pfx_d = in_pfx_byte;
                end else if (!stall) begin
                    state_d = PFX_EMPTY;
                    pfx_d   = '0;
                end
            end
            default: begin
                state_d = PFX_EMPTY;
                pfx_d   = '0;
            end
        endcase
    end

    assign live = (state_q == PFX_LIVE);
endmodule

// File: rtl/pxd_operand_extend.sv
module pxd_operand_extend #(
    parameter int PFX_W     = 8,
    parameter int SRC_IDX_W = 4,
    parameter int DST_IDX_W = 3,
    parameter int IDX_W     = 5,
    parameter int IMM_LO_W  = 8,
    parameter int SYS_REGS  = 16,
    localparam int SRC_EXT  = IDX_W - SRC_IDX_W,
    localparam int DST_EXT  = IDX_W - DST_IDX_W,
    localparam int IMM_W    = PFX_W + IMM_LO_W
) (
    input  logic                 live,
    input  logic [PFX_W-1:0]     pfx_q,
    input  logic [IMM_LO_W-1:0]  src_field,
    input  logic                 src_imm,
    input  logic [DST_IDX_W-1:0] dst_field,
    input  logic                 src_sys,
    input  logic                 dst_sys,
    output logic [IDX_W-1:0]     src_idx,
    output logic [IDX_W-1:0]     dst_idx,
    output logic [IMM_W-1:0]     imm,
    output logic                 err
);
    logic [PFX_W-1:0] eff;

    always_comb begin
        eff     = live ? pfx_q : '0;
        src_idx = {eff[SRC_EXT-1:0], src_field[SRC_IDX_W-1:0]};
        dst_idx = {eff[SRC_EXT +: DST_EXT], dst_field};
        imm     = {eff, src_field};
        err     = (src_sys && !src_imm && (src_idx >= IDX_W'(SYS_REGS)))
               || (dst_sys && (dst_idx >= IDX_W'(SYS_REGS)));
    end
endmodule

// File: rtl/pxd_operand_decoder.sv
module pxd_operand_decoder #(
    parameter int PFX_W     = 8,
    parameter int SRC_IDX_W = 4,
    parameter int DST_IDX_W = 3,
    parameter int IDX_W     = 5,
    parameter int IMM_LO_W  = 8,
    parameter int SYS_REGS  = 16,
    localparam int IMM_W    = PFX_W + IMM_LO_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stall,
    input  logic                 in_valid,
    input  logic                 in_is_prefix,
    input  logic [PFX_W-1:0]     in_pfx_byte,
    input  logic [IMM_LO_W-1:0]  in_src_field,
    input  logic                 in_src_imm,
    input  logic [DST_IDX_W-1:0] in_dst_field,
    input  logic                 in_src_sys,
    input  logic                 in_dst_sys,
    output logic                 out_valid,
    output logic [IDX_W-1:0]     out_src_idx,
    output logic [IDX_W-1:0]     out_dst_idx,
    output logic [IMM_W-1:0]     out_imm,
    output logic                 out_src_imm,
    output logic                 out_pfx_used,
    output logic                 out_err
);
    logic             live;
    logic [PFX_W-1:0] pfx_q;
    logic [IDX_W-1:0] src_idx_c, dst_idx_c;
    logic [IMM_W-1:0] imm_c;
    logic             err_c;
    logic             accept;

    pxd_prefix_fsm #(.PFX_W(PFX_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .stall        (stall),
        .in_valid     (in_valid),
        .in_is_prefix (in_is_prefix),
        .in_pfx_byte  (in_pfx_byte),
        .live         (live),
        .pfx_q        (pfx_q)
    );

    pxd_operand_extend #(
        .PFX_W     (PFX_W),
        .SRC_IDX_W (SRC_IDX_W),
        .DST_IDX_W (DST_IDX_W),
        .IDX_W     (IDX_W),
        .IMM_LO_W  (IMM_LO_W),
        .SYS_REGS  (SYS_REGS)
    ) u_ext (
        .live      (live),
        .pfx_q     (pfx_q),
        .src_field (in_src_field),
        .src_imm   (in_src_imm),
        .dst_field (in_dst_field),
        .src_sys   (in_src_sys),
        .dst_sys   (in_dst_sys),
        .src_idx   (src_idx_c),
        .dst_idx   (dst_idx_c),
        .imm       (imm_c),
        .err       (err_c)
    );

    assign accept = in_valid && !in_is_prefix && !stall;

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_src_idx  <= '0;
            out_dst_idx  <= '0;
            out_imm      <= '0;
            out_src_imm  <= 1'b0;
            out_pfx_used <= 1'b0;
            out_err      <= 1'b0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_src_idx  <= src_idx_c;
                out_dst_idx  <= dst_idx_c;
                out_imm      <= imm_c;
                out_src_imm  <= in_src_imm;
                out_pfx_used <= live;
                out_err      <= err_c;
            end
        end
    end
endmodule

// File: rtl/pxd_operand_decoder_chk.sv
module pxd_operand_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        stall,
    input logic        in_valid,
    input logic        in_is_prefix,
    input logic        in_src_sys,
    input logic        in_dst_sys,
    input logic        out_valid,
    input logic [4:0]  out_src_idx,
    input logic [4:0]  out_dst_idx,
    input logic [15:0] out_imm,
    input logic        out_src_imm,
    input logic        out_pfx_used,
    input logic        out_err
);
    a_r3_prefix_reaches_next: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_is_prefix && !stall
         && $past(in_valid && in_is_prefix && !stall && !rst)) |=> out_pfx_used);

    a_r4_no_prefix_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_pfx_used) |->
        (out_imm[15:8] == 8'h00 && !out_src_idx[4] && out_dst_idx[4:3] == 2'b00));

    a_r5_stall_blocks: assert property (@(posedge clk) disable iff (rst)
        stall |=> !out_valid);

    a_r6_range_error: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_err ==
        (($past(in_src_sys) && !out_src_imm && out_src_idx[4])
         || ($past(in_dst_sys) && out_dst_idx[4])));

    a_r7_prefix_silent: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_is_prefix) |=> !out_valid);

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_imm == 16'h0000 && !out_err && !out_pfx_used));
endmodule

bind pxd_operand_decoder pxd_operand_decoder_chk u_chk (.*);

// File: tb/pxd_operand_decoder_test.sv
`timescale 1ns/1ps
module pxd_operand_decoder_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        stall;
    logic        in_valid;
    logic        in_is_prefix;
    logic [7:0]  in_pfx_byte;
    logic [7:0]  in_src_field;
    logic        in_src_imm;
    logic [2:0]  in_dst_field;
    logic        in_src_sys;
    logic        in_dst_sys;
    logic        out_valid;
    logic [4:0]  out_src_idx;
    logic [4:0]  out_dst_idx;
    logic [15:0] out_imm;
    logic        out_src_imm;
    logic        out_pfx_used;
    logic        out_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    pxd_operand_decoder uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        in_valid = 0; in_is_prefix = 0; stall = 0;
        @(negedge clk);
    endtask

    task automatic pfx(input logic [7:0] b);
        in_valid = 1; in_is_prefix = 1; in_pfx_byte = b; stall = 0;
        @(negedge clk);
        in_valid = 0; in_is_prefix = 0;
    endtask

    task automatic ins(input logic [7:0] sf, input logic si, input logic [2:0] df,
                       input logic ss, input logic ds);
        in_valid = 1; in_is_prefix = 0; stall = 0;
        in_src_field = sf; in_src_imm = si; in_dst_field = df;
        in_src_sys = ss; in_dst_sys = ds;
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic t_reset();
        rst = 1; idle(); idle();
        chk("R9 valid", out_valid, 0);
        chk("R9 imm", out_imm, 0);
        chk("R9 err", out_err, 0);
        rst = 0;
    endtask

    task automatic t_plain();
        ins(8'h25, 0, 3'h3, 0, 0);
        chk("R7 valid", out_valid, 1);
        chk("R1 src", out_src_idx, 5'h05);
        chk("R1 dst", out_dst_idx, 5'h03);
        chk("R8 no pfx", out_pfx_used, 0);
        ins(8'hA5, 1, 3'h0, 0, 0);
        chk("R4 imm", out_imm, 16'h00A5);
        idle();
        chk("R7 idle", out_valid, 0);
    endtask

    task automatic t_prefix_imm();
        pfx(8'h12);
        chk("R7 pfx silent", out_valid, 0);
        ins(8'h34, 1, 3'h0, 0, 0);
        chk("R2 imm", out_imm, 16'h1234);
        chk("R8 used", out_pfx_used, 1);
        ins(8'h34, 1, 3'h0, 0, 0);
        chk("R3 one shot imm", out_imm, 16'h0034);
        chk("R3 one shot used", out_pfx_used, 0);
    endtask

    task automatic t_prefix_idx();
        pfx(8'h07);
        ins(8'h0A, 0, 3'h5, 0, 0);
        chk("R1 src ext", out_src_idx, 5'h1A);
        chk("R1 dst ext", out_dst_idx, 5'h1D);
        pfx(8'h04);
        ins(8'h0F, 0, 3'h1, 0, 0);
        chk("R1 dst bit4 only", out_dst_idx, 5'h11);
        chk("R1 src no ext", out_src_idx, 5'h0F);
    endtask

    task automatic t_expire_gap();
        pfx(8'hFF);
        idle();
        ins(8'h01, 1, 3'h2, 0, 0);
        chk("R3 expired imm", out_imm, 16'h0001);
        chk("R4 expired used", out_pfx_used, 0);
    endtask

    task automatic t_reload();
        pfx(8'hAA);
        pfx(8'h5B);
        ins(8'h00, 1, 3'h0, 0, 0);
        chk("R3 reload imm", out_imm, 16'h5B00);
    endtask

    task automatic t_stall();
        pfx(8'h3C);
        in_valid = 1; in_is_prefix = 0; stall = 1;
        in_src_field = 8'h11; in_src_imm = 1; in_dst_field = 0;
        in_src_sys = 0; in_dst_sys = 0;
        @(negedge clk);
        chk("R5 stall valid", out_valid, 0);
        @(negedge clk);
        chk("R5 stall valid 2", out_valid, 0);
        stall = 0;
        @(negedge clk);
        in_valid = 0;
        chk("R5 held imm", out_imm, 16'h3C11);
        chk("R5 held used", out_pfx_used, 1);
    endtask

    task automatic t_errors();
        pfx(8'h01);
        ins(8'h00, 0, 3'h0, 1, 0);
        chk("R6 sys src 10h", out_err, 1);
        pfx(8'h01);
        ins(8'h0F, 0, 3'h0, 0, 0);
        chk("R6 periph src 1Fh", out_err, 0);
        ins(8'h0F, 0, 3'h7, 1, 1);
        chk("R6 sys 0Fh and 07h", out_err, 0);
        pfx(8'h04);
        ins(8'h00, 0, 3'h0, 0, 1);
        chk("R6 sys dst 10h", out_err, 1);
        pfx(8'h02);
        ins(8'h00, 0, 3'h7, 0, 1);
        chk("R6 sys dst 0Fh", out_err, 0);
        pfx(8'h01);
        ins(8'hFF, 1, 3'h0, 1, 0);
        chk("R6 imm no err", out_err, 0);
    endtask

    task automatic t_reset_live();
        pfx(8'h77);
        rst = 1; @(negedge clk); rst = 0;
        chk("R9 reset out", out_valid, 0);
        ins(8'h05, 1, 3'h0, 0, 0);
        chk("R9 prefix cleared", out_imm, 16'h0005);
        chk("R9 prefix cleared used", out_pfx_used, 0);
    endtask

    initial begin
        rst = 1; stall = 0; in_valid = 0; in_is_prefix = 0; in_pfx_byte = 0;
        in_src_field = 0; in_src_imm = 0; in_dst_field = 0;
        in_src_sys = 0; in_dst_sys = 0;
        @(negedge clk);
        t_reset();
        t_plain();
        t_prefix_imm();
        t_prefix_idx();
        t_expire_gap();
        t_reload();
        t_stall();
        t_errors();
        t_reset_live();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #20000;
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule